// File: doc/BRIEF.md
# Four-Lane SD Data CRC16 Engine

This block produces the data checksum used on a four-wire SD data bus. Each of the four data wires carries its own serial stream, and the block runs one CRC16 generator per wire. Every clock in which a data nibble is presented, bit k of the nibble is fed into the generator of wire k. Data bytes are placed on the bus high nibble first. A 512-byte block therefore takes 1024 nibbles, and 16 checksum nibbles follow it.

The four 16-bit results are presented as one 64-bit word in interleaved form. Nibble j of the word holds bit j of every lane, so the word can be sent or checked directly as 16 bus nibbles, with the most significant nibble first. On the transmit side a start pulse makes the block play those 16 nibbles out, one per clock. On the receive side the host feeds in the 16 checksum nibbles that came off the bus. The block then raises either a match flag or an error flag. A synchronous clear zeroes all lanes before each block.

Top module: `sd4_crc16`

## Requirements
- R1: After reset, `crc_out` is zero and `tx_vld`, `match` and `crc_err` are low.
- R2: Each lane is a CRC16 with generator x^16+x^12+x^5+1 (0x1021) and initial value zero, fed MSB-first. On a clock with `data_vld` high and `clr` low, lane k shifts in `data_nib[k]`. For example, lane 0 fed the nine ASCII bytes "123456789" MSB-first ends at 0x31C3.
- R3: On a clock with `data_vld` and `clr` both low, `crc_out` does not change, whatever `data_nib` holds.
- R4: `clr` high at a clock edge zeroes all four lanes, overriding `data_vld`. It also aborts any transmit or compare in progress and lowers `match` and `crc_err`.
- R5: Bit 4*j+k of `crc_out` is bit j of lane k's register.
- R6: A `tx_start` pulse while idle raises `tx_vld` from the next cycle for exactly 16 cycles. In the i-th of those cycles (i = 0..15), `tx_nib` equals `crc_out[4*(15-i)+3 : 4*(15-i)]`, so the most significant nibble comes first.
- R7: `tx_start` while `tx_vld` is high is ignored. The running sequence neither restarts nor lengthens.
- R8: The i-th nibble presented with `rx_vld` (i = 0..15) is compared with `crc_out` nibble 15-i. If all 16 are equal, `match` goes high on the edge that takes the 16th nibble.
- R9: If any of the 16 nibbles differs, `crc_err` goes high instead of `match`. `match` and `crc_err` are never high together. Each result holds until `clr` or until the first nibble of the next compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of lanes, sequencers and flags |
| data_vld | input | 1 | Data nibble valid |
| data_nib | input | 4 | Data nibble, bit k is data wire k |
| tx_start | input | 1 | Start playing out the 16 checksum nibbles |
| tx_vld | output | 1 | Checksum nibble on tx_nib is valid |
| tx_nib | output | 4 | Outgoing checksum nibble |
| rx_vld | input | 1 | Received checksum nibble valid |
| rx_nib | input | 4 | Received checksum nibble |
| crc_out | output | 64 | Interleaved checksum of all four lanes |
| match | output | 1 | Received checksum equals computed checksum |
| crc_err | output | 1 | Received checksum differs from computed checksum |

## Verification
The assertions check the following on every cycle:
- a clear leaves the checksum at zero;
- an idle data input leaves it unchanged;
- match and error are never both high;
- an idle start pulse opens a transmit window;
- a start pulse during transmission does not disturb the nibble index.

The bench's scenarios are needed to show the rest:
- the actual CRC values, against a reference computed arithmetically, including a known check value;
- the nibble interleave;
- the most-significant-first transmit order;
- compare outcomes with a correct checksum and with a corrupted one.

The bench sweeps every single-nibble and two-nibble input from a cleared state and runs a full 1024-nibble block.

// File: rtl/sd4_crc_pkg.sv
package sd4_crc_pkg;
    localparam int CRC_W      = 16;
    localparam int LANES      = 4;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/sd4_crc_lane.sv
module sd4_crc_lane #(
    parameter int W = sd4_crc_pkg::CRC_W,
    parameter logic [W-1:0] POLY = sd4_crc_pkg::CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    logic [W-1:0] crc_d, crc_q;

    function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic b);
        logic fb;
        fb = c[W-1] ^ b;
        return {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    endfunction

    always_comb begin
        crc_d = crc_q;
        if (clr)
            crc_d = '0;
        else if (en)
            crc_d = step(crc_q, bit_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc)); // R3
endmodule

// File: rtl/sd4_crc_tx.sv
module sd4_crc_tx #(
    parameter int LANES = sd4_crc_pkg::LANES,
    parameter int NIBS  = sd4_crc_pkg::CRC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  start,
    input  logic [LANES*NIBS-1:0] word,
    output logic                  vld,
    output logic [LANES-1:0]      nib
);
    localparam int IDX_W = $clog2(NIBS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBS - 1);

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (st_q.act) begin
            if (st_q.idx == LAST) begin
                st_d.act = 1'b0;
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.act = 1'b1;
            st_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        nib = '0;
        for (int j = 0; j < NIBS; j++) begin
            if (IDX_W'(NIBS - 1 - j) == st_q.idx)
                nib = word[j*LANES +: LANES];
        end
    end

    assign vld = st_q.act;

    AST_TX_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && start && !clr) |=> (vld && st_q.idx == '0)); // R6
    AST_TX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && start && !clr && st_q.idx != LAST) |=> (vld && st_q.idx == $past(st_q.idx) + 1'b1)); // R7
endmodule

// File: rtl/sd4_crc_rx.sv
module sd4_crc_rx #(
    parameter int LANES = sd4_crc_pkg::LANES,
    parameter int NIBS  = sd4_crc_pkg::CRC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  vld,
    input  logic [LANES-1:0]      nib,
    input  logic [LANES*NIBS-1:0] word,
    output logic                  match,
    output logic                  err
);
    localparam int IDX_W = $clog2(NIBS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             bad;
        logic             match;
        logic             err;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [LANES-1:0] expect_nib;
    logic             bad_now;

    always_comb begin
        expect_nib = '0;
        for (int j = 0; j < NIBS; j++) begin
            if (IDX_W'(NIBS - 1 - j) == st_q.idx)
                expect_nib = word[j*LANES +: LANES];
        end
    end

    always_comb begin
        st_d    = st_q;
        bad_now = ((st_q.idx != '0) && st_q.bad) || (nib != expect_nib);
        if (clr) begin
            st_d = '0;
        end else if (vld) begin
            if (st_q.idx == '0) begin
                st_d.match = 1'b0;
                st_d.err   = 1'b0;
            end
            if (st_q.idx == LAST) begin
                st_d.idx   = '0;
                st_d.bad   = 1'b0;
                st_d.match = !bad_now;
                st_d.err   = bad_now;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.bad = bad_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match = st_q.match;
    assign err   = st_q.err;

    AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && err)); // R9
    AST_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!match && !err)); // R4
endmodule

// File: rtl/sd4_crc16.sv
module sd4_crc16 #(
    parameter int LANES = sd4_crc_pkg::LANES,
    parameter int CRC_W = sd4_crc_pkg::CRC_W,
    parameter logic [CRC_W-1:0] POLY = sd4_crc_pkg::CRC_POLY
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   data_vld,
    input  logic [LANES-1:0]       data_nib,
    input  logic                   tx_start,
    output logic                   tx_vld,
    output logic [LANES-1:0]       tx_nib,
    input  logic                   rx_vld,
    input  logic [LANES-1:0]       rx_nib,
    output logic [LANES*CRC_W-1:0] crc_out,
    output logic                   match,
    output logic                   crc_err
);
    localparam int TOT_W = LANES * CRC_W;

    logic [CRC_W-1:0] lane_crc [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sd4_crc_lane #(.W(CRC_W), .POLY(POLY)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .en     (data_vld),
            .bit_in (data_nib[k]),
            .crc    (lane_crc[k])
        );
        for (genvar j = 0; j < CRC_W; j++) begin : g_bit
            assign crc_out[j*LANES + k] = lane_crc[k][j];
        end
    end

    sd4_crc_tx #(.LANES(LANES), .NIBS(CRC_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .start (tx_start),
        .word  (crc_out),
        .vld   (tx_vld),
        .nib   (tx_nib)
    );

    sd4_crc_rx #(.LANES(LANES), .NIBS(CRC_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .vld   (rx_vld),
        .nib   (rx_nib),
        .word  (crc_out),
        .match (match),
        .err   (crc_err)
    );

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_out == TOT_W'(0))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !data_vld) |=> $stable(crc_out)); // R3
endmodule

// File: tb/sim_sd4_crc16.sv
module sim_sd4_crc16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        data_vld = 1'b0;
    logic [3:0]  data_nib = '0;
    logic        tx_start = 1'b0;
    logic        tx_vld;
    logic [3:0]  tx_nib;
    logic        rx_vld = 1'b0;
    logic [3:0]  rx_nib = '0;
    logic [63:0] crc_out;
    logic        match;
    logic        crc_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] ref_lane [4];

    always #2 clk = ~clk;

    sd4_crc16 u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .data_vld(data_vld), .data_nib(data_nib),
        .tx_start(tx_start), .tx_vld(tx_vld), .tx_nib(tx_nib),
        .rx_vld(rx_vld), .rx_nib(rx_nib), .crc_out(crc_out), .match(match), .crc_err(crc_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = {c[14:0], 1'b0};
        if (c[15] ^ b) r = r ^ 16'h1021;
        return r;
    endfunction

    function automatic logic [63:0] ref_word();
        logic [63:0] w;
        for (int j = 0; j < 16; j++)
            for (int k = 0; k < 4; k++)
                w[4*j+k] = ref_lane[k][j];
        return w;
    endfunction

    task automatic do_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int k = 0; k < 4; k++) ref_lane[k] = '0;
    endtask

    task automatic feed(input logic [3:0] n);
        data_vld = 1'b1;
        data_nib = n;
        @(negedge clk);
        data_vld = 1'b0;
        for (int k = 0; k < 4; k++) ref_lane[k] = ref_step(ref_lane[k], n[k]);
    endtask

    task automatic feed_byte(input logic [7:0] b);
        feed(b[7:4]);
        feed(b[3:0]);
    endtask

    task automatic rx_seq(input int flip);
        logic [63:0] w;
        w = ref_word();
        for (int i = 0; i < 16; i++) begin
            rx_vld = 1'b1;
            rx_nib = w[4*(15-i) +: 4] ^ ((i == flip) ? 4'h8 : 4'h0);
            @(negedge clk);
            if (i == 0) chk("R9 flags cleared at first nibble", {62'd0, match, crc_err}, 64'd0);
        end
        rx_vld = 1'b0;
        if (flip < 0) chk("R8 match", {62'd0, match, crc_err}, 64'd2);
        else          chk("R9 crc_err", {62'd0, match, crc_err}, 64'd1);
    endtask

    task automatic tx_seq();
        logic [63:0] w;
        w = ref_word();
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            chk("R6 tx_vld", {63'd0, tx_vld}, 64'd1);
            chk("R6 tx_nib", {60'd0, tx_nib}, {60'd0, w[4*(15-i) +: 4]});
            tx_start = (i == 5 || i == 14);
            @(negedge clk);
            tx_start = 1'b0;
        end
        chk("R7 tx window not extended", {63'd0, tx_vld}, 64'd0);
    endtask

    initial begin
        logic [7:0] msg [9];
        logic [15:0] lfsr;
        logic [15:0] l0;
        for (int k = 0; k < 4; k++) ref_lane[k] = '0;
        repeat (3) @(negedge clk);
        chk("R1 crc_out reset", crc_out, 64'd0);
        chk("R1 flags reset", {61'd0, tx_vld, match, crc_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 known check value on lane 0
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        do_clr();
        for (int i = 0; i < 9; i++)
            for (int b = 7; b >= 0; b--) feed({3'b000, msg[i][b]});
        for (int j = 0; j < 16; j++) l0[j] = crc_out[4*j];
        chk("R2 lane0 check value", {48'd0, l0}, 64'h31C3);
        chk("R5 other lanes zero", crc_out & ~64'h1111_1111_1111_1111, 64'd0);

        // R2 R5 exhaustive single-nibble and two-nibble sweep
        for (int a = 0; a < 16; a++) begin
            do_clr();
            feed(4'(a));
            chk("R2 R5 single nibble", crc_out, ref_word());
            for (int b = 0; b < 16; b++) begin
                do_clr();
                feed(4'(a));
                feed(4'(b));
                chk("R2 R5 nibble pair", crc_out, ref_word());
            end
        end

        // R3 idle data input ignored
        data_nib = 4'hF;
        repeat (3) @(negedge clk);
        chk("R3 idle hold", crc_out, ref_word());

        // R4 clr overrides data_vld
        clr = 1'b1; data_vld = 1'b1; data_nib = 4'hA;
        @(negedge clk);
        clr = 1'b0; data_vld = 1'b0;
        for (int k = 0; k < 4; k++) ref_lane[k] = '0;
        chk("R4 clr zero", crc_out, 64'd0);

        // full block, pseudo-random bytes, high nibble first
        lfsr = 16'hACE1;
        for (int i = 0; i < 512; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            feed_byte(lfsr[7:0]);
        end
        chk("R2 full block", crc_out, ref_word());
        tx_seq();
        rx_seq(-1);
        rx_seq(7);
        rx_seq(-1);

        // all-ones block
        do_clr();
        for (int i = 0; i < 512; i++) feed_byte(8'hFF);
        chk("R2 all ones block", crc_out, ref_word());
        tx_seq();
        rx_seq(0);

        // R4 clr aborts transmit and clears flags
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int k = 0; k < 4; k++) ref_lane[k] = '0;
        chk("R4 clr aborts tx and flags", {61'd0, tx_vld, match, crc_err}, 64'd0);
        chk("R4 zero after clr", crc_out, 64'd0);
        rx_seq(-1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule